// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable model of a synchronous static RAM with a registered read path and a built-in four-beat burst counter. Every control input is sampled on the rising clock edge. Address, chip selects, two burst-start strobes, the advance input and the write controls are all captured there. Read data passes through an output register before it reaches the 32-bit data bus, so a read costs one more cycle than in a flow-through memory. A write can store any mix of the four byte lanes.

There are two burst-start strobes, one for a CPU and one for a cache controller. The CPU strobe is qualified by the first chip select and always begins a read. The controller strobe is not qualified that way, and it may begin either a read or a write. Once a burst is open, further cycles either step to the next address in the chosen order or hold the current address to insert a wait state. The bus drive enable is asynchronous: it combines the output-enable pin with a registered flag saying the last output-register load came from a read. `ADDR_W` sets the depth; 16 gives the full 64K-word array.

Top module: `pipe_burst_sram`

## Requirements
- R1: After reset `rdata_oe_o` is 0 and `rdata_o` is 0, and no burst is open.
- R2: While `wr_byte_ni` is 0 in a write cycle, `lane_ni[k]`=0 stores `wdata_i[8k+7:8k]` and `lane_ni[k]`=1 leaves that byte unchanged (k = 0..3).
- R3: `wr_all_ni`=0 makes the cycle a write of all four bytes, whatever `wr_byte_ni` and `lane_ni` are.
- R4: A cycle is a read when `wr_all_ni`=1 and either `wr_byte_ni`=1 or `lane_ni`=4'hF.
- R5: A burst opens only when `sel_a_ni`=0, `sel_b_i`=1 and `sel_c_ni`=0. An effective strobe with any select inactive closes the burst. Later cycles then neither read nor write, and `rdata_oe_o` is 0 after the second following edge.
- R6: `cpu_strb_ni` is ignored while `sel_a_ni`=1. With `ctl_strb_ni`=0 that cycle deselects; with `ctl_strb_ni`=1 an open burst continues.
- R7: An effective `cpu_strb_ni`=0 starts a read at `addr_i` even when the write controls are asserted. A write to that burst happens on a following edge that has both strobes high.
- R8: With both strobes high in an open burst, `step_ni`=0 moves to the next burst address and `step_ni`=1 reuses the current one (wait state).
- R9: The burst changes only address bits [1:0]. With `seq_lin_i`=1 the k-th beat is `(start+k) mod 4`; with `seq_lin_i`=0 it is `start XOR k`.
- R10: Data for a read registered at edge N appears on `rdata_o` after edge N+1 and holds until the next read loads the output register.
- R11: `rdata_oe_o` is `~out_en_ni` ANDed with a registered flag that the previous edge loaded a read, and it follows `out_en_ni` without a clock.
- R12: A write cycle leaves `rdata_o` unchanged, and `rdata_oe_o` is 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| sel_a_ni | input | 1 | Chip select A, active low, also qualifies the CPU strobe |
| sel_b_i | input | 1 | Chip select B, active high |
| sel_c_ni | input | 1 | Chip select C, active low |
| cpu_strb_ni | input | 1 | CPU burst-start strobe, active low |
| ctl_strb_ni | input | 1 | Controller burst-start strobe, active low |
| step_ni | input | 1 | Burst advance, active low; high suspends |
| wr_all_ni | input | 1 | Write all bytes, active low |
| wr_byte_ni | input | 1 | Byte-write qualifier, active low |
| lane_ni | input | 4 | Per-byte write enables, active low |
| seq_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| out_en_ni | input | 1 | Output enable, active low, asynchronous |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Output register contents |
| rdata_oe_o | output | 1 | Bus drive enable |

## Verification
A wrong burst counter or base register shows up as the wrong word on `rdata_o` one edge after the faulty address is used. In a read burst this is the next cycle. In a write burst it shows only when those words are read back. A stale burst-open flag shows up as writes that land after a deselect, or as `rdata_oe_o` rising two edges after a cycle that should have been idle. A reference model runs in lockstep with the design and compares both outputs every cycle. Directed bursts pin down the wrap order, suspend and strobe-gating cases with explicit values.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              cpu_strb_ni,
  input  logic              ctl_strb_ni,
  input  logic              step_ni,
  input  logic              wr_all_ni,
  input  logic              wr_byte_ni,
  input  logic [LANES-1:0]  lane_ni,
  input  logic              seq_lin_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  mask_o
);
  localparam int CNT_W = 2;

  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d, base_use;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_use;
  logic              sel_ok, cpu_go, ctl_go, wr_req;
  logic [CNT_W-1:0]  low_bits;

  assign sel_ok = !sel_a_ni && sel_b_i && !sel_c_ni;
  assign cpu_go = !cpu_strb_ni && !sel_a_ni;    // CPU strobe masked by select A
  assign ctl_go = !ctl_strb_ni && !cpu_go;       // CPU strobe wins when both low
  assign wr_req = !wr_all_ni || (!wr_byte_ni && !(&lane_ni));

  always_comb begin
    op_o     = OP_NONE;
    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    base_use = base_q;
    cnt_use  = cnt_q;
    if (cpu_go || ctl_go) begin
      if (sel_ok) begin
        active_d = 1'b1;
        base_d   = addr_i;
        cnt_d    = '0;
        base_use = addr_i;
        cnt_use  = '0;
        op_o     = (ctl_go && wr_req) ? OP_WR : OP_RD;
      end else begin
        active_d = 1'b0;
      end
    end else if (active_q) begin
      if (!step_ni) begin
        cnt_use = cnt_q + 1'b1;
        cnt_d   = cnt_use;
      end
      op_o = wr_req ? OP_WR : OP_RD;
    end
  end

  assign low_bits = seq_lin_i ? (base_use[CNT_W-1:0] + cnt_use)
                              : (base_use[CNT_W-1:0] ^ cnt_use);
  assign addr_o   = {base_use[ADDR_W-1:CNT_W], low_bits};
  assign mask_o   = !wr_all_ni ? {LANES{1'b1}} : (!wr_byte_ni ? ~lane_ni : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
    end
  end

  logic cont_cyc, hold_cyc;
  assign cont_cyc = active_q && !cpu_go && ctl_strb_ni && !step_ni;
  assign hold_cyc = active_q && !cpu_go && ctl_strb_ni && step_ni;

  AST_SUSPEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cyc |-> addr_o == $past(addr_o)); // R8

  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cont_cyc && seq_lin_i && $past(seq_lin_i)) |->
      (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1) &&
      (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]))); // R9
endmodule

// File: rtl/pbs_array.sv
module pbs_array
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && mask_i[l]) mem[waddr_i] <= wdata_i[l*BYTE_W +: BYTE_W];
    end

    assign rdata_o[l*BYTE_W +: BYTE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_a_ni,
  input  logic              sel_b_i,
  input  logic              sel_c_ni,
  input  logic              cpu_strb_ni,
  input  logic              ctl_strb_ni,
  input  logic              step_ni,
  input  logic              wr_all_ni,
  input  logic              wr_byte_ni,
  input  logic [3:0]        lane_ni,
  input  logic              seq_lin_i,
  input  logic              out_en_ni,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rdata_oe_o
);
  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_mask;
  logic [DATA_W-1:0] arr_rdata;

  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] dout_q;
  logic              oe_dly_q;

  pbs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .sel_a_ni    (sel_a_ni),
    .sel_b_i     (sel_b_i),
    .sel_c_ni    (sel_c_ni),
    .cpu_strb_ni (cpu_strb_ni),
    .ctl_strb_ni (ctl_strb_ni),
    .step_ni     (step_ni),
    .wr_all_ni   (wr_all_ni),
    .wr_byte_ni  (wr_byte_ni),
    .lane_ni     (lane_ni),
    .seq_lin_i   (seq_lin_i),
    .op_o        (op),
    .addr_o      (op_addr),
    .mask_o      (op_mask)
  );

  pbs_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (op == OP_WR),
    .mask_i  (op_mask),
    .waddr_i (op_addr),
    .wdata_i (wdata_i),
    .raddr_i (rd_addr_q),
    .rdata_o (arr_rdata)
  );

  // address register stage, then output register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      dout_q    <= '0;
      oe_dly_q  <= 1'b0;
    end else begin
      rd_pend_q <= (op == OP_RD);
      if (op == OP_RD) rd_addr_q <= op_addr;
      if (rd_pend_q) dout_q <= arr_rdata;
      oe_dly_q <= rd_pend_q;
    end
  end

  assign rdata_o    = dout_q;
  assign rdata_oe_o = oe_dly_q && !out_en_ni;

  logic cpu_start_ok, desel_evt;
  assign cpu_start_ok = !cpu_strb_ni && !sel_a_ni && sel_b_i && !sel_c_ni;
  assign desel_evt    = !ctl_strb_ni && sel_a_ni;

  AST_CPU_STRB_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(cpu_start_ok, 2)) |-> oe_dly_q); // R7

  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(desel_evt, 2)) |-> !oe_dly_q); // R5

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && $past(op == OP_WR, 2)) |-> !oe_dly_q); // R12

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WR && !wr_all_ni) |-> (&op_mask)); // R3
endmodule

// File: tb/tb_pipe_burst_sram.sv
`timescale 1ns/1ps
module tb_pipe_burst_sram;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sa = 1'b1, sb = 1'b1, sc = 1'b0;
  logic          cs = 1'b1, ks = 1'b1, stp = 1'b1;
  logic          gwa = 1'b1, wb = 1'b1;
  logic [3:0]    ln = 4'hF;
  logic          lin = 1'b1, oe_n = 1'b0;
  logic [31:0]   wd = '0;
  logic [31:0]   rdata;
  logic          rdata_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  pipe_burst_sram #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .sel_a_ni(sa), .sel_b_i(sb), .sel_c_ni(sc),
    .cpu_strb_ni(cs), .ctl_strb_ni(ks), .step_ni(stp),
    .wr_all_ni(gwa), .wr_byte_ni(wb), .lane_ni(ln),
    .seq_lin_i(lin), .out_en_ni(oe_n), .wdata_i(wd),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  always #2.5 clk = ~clk;

  // reference model built from the requirements
  logic [31:0]   m_mem [DEPTH];
  logic          m_act = 1'b0, m_pend = 1'b0, m_oedly = 1'b0;
  logic [AW-1:0] m_base = '0, m_raddr = '0;
  logic [1:0]    m_cnt = '0;
  logic [31:0]   m_dout = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_pend = 0; m_oedly = 0; m_base = '0; m_raddr = '0;
      m_cnt = '0; m_dout = '0;
    end else begin
      logic ok, cpu, ctl, wr;
      logic [AW-1:0] ea;
      logic [1:0] lo;
      int kind;
      if (m_pend) m_dout = m_mem[m_raddr];
      m_oedly = m_pend;
      m_pend  = 1'b0;
      ok  = !sa && sb && !sc;
      cpu = !cs && !sa;
      ctl = !ks && !cpu;
      wr  = !gwa || (!wb && ln != 4'hF);
      kind = 0;
      if (cpu || ctl) begin
        if (ok) begin
          m_act = 1; m_base = addr; m_cnt = 0;
          kind = (ctl && wr) ? 2 : 1;
        end else m_act = 0;
      end else if (m_act) begin
        if (!stp) m_cnt = m_cnt + 2'd1;
        kind = wr ? 2 : 1;
      end
      lo = lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
      ea = {m_base[AW-1:2], lo};
      if (kind == 2) begin
        for (int l = 0; l < 4; l++)
          if (!gwa || (!wb && !ln[l])) m_mem[ea][l*8 +: 8] = wd[l*8 +: 8];
      end else if (kind == 1) begin
        m_pend = 1'b1; m_raddr = ea;
      end
    end
  end

  function automatic logic [31:0] fillv(input int a);
    return 32'hC0DE_0000 | 32'(a * 32'h0101);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk({cur_tag, " oe"}, {31'd0, rdata_oe}, {31'd0, m_oedly && !oe_n});
    chk({cur_tag, " data"}, rdata, m_dout);
  endtask

  task automatic pins(input logic a_, b_, c_, cs_, ks_, st_, g_, w_,
                      input logic [3:0] l_, input logic [AW-1:0] ad, input logic [31:0] d);
    sa = a_; sb = b_; sc = c_; cs = cs_; ks = ks_; stp = st_;
    gwa = g_; wb = w_; ln = l_; addr = ad; wd = d;
  endtask

  task automatic desel();   pins(1,1,0, 1,0,1, 1,1,4'hF, '0, '0); tick(); endtask
  task automatic go_cpu(input logic [AW-1:0] a); pins(0,1,0, 0,1,1, 1,1,4'hF, a, '0); tick(); endtask
  task automatic go_ctl_rd(input logic [AW-1:0] a); pins(0,1,0, 1,0,1, 1,1,4'hF, a, '0); tick(); endtask
  task automatic go_ctl_wr(input logic [AW-1:0] a, input logic g, w, input logic [3:0] l,
                           input logic [31:0] d);
    pins(0,1,0, 1,0,1, g,w,l, a, d); tick();
  endtask
  task automatic cont_rd(); pins(0,1,0, 1,1,0, 1,1,4'hF, '0, '0); tick(); endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    chk("R1 oe after reset", {31'd0, rdata_oe}, 32'd0);
    chk("R1 data after reset", rdata, 32'd0);
    rst_n = 1'b1;
    desel();

    // fill every word with global-write bursts
    cur_tag = "R3";
    lin = 1'b1;
    for (int b = 0; b < DEPTH / 4; b++) begin
      pins(0,1,0, 1,0,1, 0,1,4'hF, AW'(b*4), fillv(b*4)); tick();
      for (int i = 1; i < 4; i++) begin
        pins(0,1,0, 1,1,0, 0,1,4'hF, '0, fillv(b*4+i)); tick();
      end
    end
    desel();

    // linear burst with wrap, read latency
    cur_tag = "R10";
    go_cpu(8'h12);
    cont_rd(); chk("R10 first beat", rdata, fillv(8'h12));
    chk("R10 oe", {31'd0, rdata_oe}, 32'd1);
    cont_rd(); chk("R9 linear beat1", rdata, fillv(8'h13));
    cont_rd(); chk("R9 linear wrap", rdata, fillv(8'h10));
    desel();   chk("R9 linear beat3", rdata, fillv(8'h11));
    desel();   chk("R5 bus idle after deselect", {31'd0, rdata_oe}, 32'd0);

    // interleaved order
    cur_tag = "R9";
    lin = 1'b0;
    go_ctl_rd(8'h11);
    cont_rd(); chk("R9 ilv beat0", rdata, fillv(8'h11));
    cont_rd(); chk("R9 ilv beat1", rdata, fillv(8'h10));
    cont_rd(); chk("R9 ilv beat2", rdata, fillv(8'h13));
    desel();   chk("R9 ilv beat3", rdata, fillv(8'h12));
    lin = 1'b1;
    desel();

    // suspend
    cur_tag = "R8";
    go_cpu(8'h20);
    pins(0,1,0, 1,1,1, 1,1,4'hF, '0, '0); tick();
    chk("R8 beat0", rdata, fillv(8'h20));
    cont_rd(); chk("R8 suspended repeat", rdata, fillv(8'h20));
    desel();   chk("R8 advance after wait", rdata, fillv(8'h21));
    // R11: async output enable
    oe_n = 1'b1; #1;
    chk("R11 oe_n high disables", {31'd0, rdata_oe}, 32'd0);
    oe_n = 1'b0; #1;
    chk("R11 oe_n low enables", {31'd0, rdata_oe}, 32'd1);
    desel();

    // byte lanes, write keeps output register
    cur_tag = "R2";
    go_ctl_wr(8'h30, 1'b1, 1'b0, 4'b1010, 32'hFFFF_FFFF);
    chk("R12 data held on write", rdata, fillv(8'h21));
    desel();
    chk("R12 no drive after write", {31'd0, rdata_oe}, 32'd0);
    go_cpu(8'h30); desel();
    chk("R2 lanes 0 and 2", rdata, fillv(8'h30) | 32'h00FF_00FF);

    cur_tag = "R3";
    go_ctl_wr(8'h31, 1'b0, 1'b0, 4'hE, 32'h1234_5678);
    go_cpu(8'h31); desel();
    chk("R3 global write all bytes", rdata, 32'h1234_5678);

    cur_tag = "R4";
    go_ctl_wr(8'h32, 1'b1, 1'b0, 4'hF, 32'hAAAA_AAAA);
    pins(0,1,0, 1,1,0, 1,1,4'h0, '0, 32'hBBBB_BBBB); tick();
    chk("R4 all lanes off is read", rdata, fillv(8'h32));
    desel();
    chk("R4 byte qual off is read", rdata, fillv(8'h33));

    cur_tag = "R7";
    pins(0,1,0, 0,1,1, 0,1,4'hF, 8'h34, 32'hDEAD_BEEF); tick();
    pins(0,1,0, 1,1,1, 0,1,4'hF, '0, 32'hDEAD_BEEF); tick();
    chk("R7 cpu start reads old", rdata, fillv(8'h34));
    desel();
    go_cpu(8'h34); desel();
    chk("R7 write on following edge", rdata, 32'hDEAD_BEEF);

    cur_tag = "R5";
    go_ctl_wr(8'h38, 1'b0, 1'b1, 4'hF, 32'h1111_1111);
    pins(0,1,1, 0,1,1, 0,1,4'hF, 8'h38, 32'h2222_2222); tick();
    pins(0,1,0, 1,1,0, 0,1,4'hF, '0, 32'h2222_2222); tick();
    pins(0,1,0, 1,1,0, 0,1,4'hF, '0, 32'h2222_2222); tick();
    chk("R5 no read after close", {31'd0, rdata_oe}, 32'd0);
    go_cpu(8'h38);
    cont_rd(); chk("R5 word0", rdata, 32'h1111_1111);
    cont_rd(); chk("R5 word1 untouched", rdata, fillv(8'h39));
    desel();   chk("R5 word2 untouched", rdata, fillv(8'h3A));
    desel();

    cur_tag = "R6";
    go_cpu(8'h40);
    pins(1,1,0, 0,1,0, 1,1,4'hF, 8'h50, '0); tick();
    chk("R6 beat0", rdata, fillv(8'h40));
    desel();
    chk("R6 masked cpu strobe continues", rdata, fillv(8'h41));
    chk("R6 still driving", {31'd0, rdata_oe}, 32'd1);
    desel();

    // constrained random, compared against the model each cycle
    cur_tag = "random";
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      if (n % 500 == 0) lin = $urandom_range(1, 0);
      sa   = ($urandom_range(9, 0) < 2);
      sb   = ($urandom_range(9, 0) != 0);
      sc   = ($urandom_range(9, 0) == 0);
      cs   = ($urandom_range(9, 0) > 1);
      ks   = ($urandom_range(9, 0) > 1);
      stp  = $urandom_range(1, 0);
      gwa  = ($urandom_range(9, 0) > 1);
      wb   = ($urandom_range(9, 0) > 2);
      ln   = 4'($urandom);
      oe_n = ($urandom_range(9, 0) < 2);
      addr = AW'($urandom);
      wd   = $urandom;
      tick();
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule